// File: doc/BRIEF.md
# Aligned Frame Pulse Generator

This block makes two frame-timing pulses from one fast reference clock. The frame output runs at 8 kHz and the multiframe output runs at 2 kHz. Both come from one shared counter chain. The multiframe period is built from exactly four frame periods, so every multiframe period starts in the same cycle as a frame period. The two outputs therefore cannot drift apart, and the multiframe edge can serve as the common phase reference for other timing outputs.

Each output has its own 2-bit mode select and its own 16-bit width value. An output can be a 50% square wave, a pulse of programmable width counted in reference cycles, or disabled. A disabled output drives its output-enable flag low and its pulse low, while its counters keep running. A synchronous restart input sets the counter chain back to the start of a multiframe. At the default 77.76 MHz reference, a frame is 9720 cycles and a multiframe is 38880 cycles. Both counts are parameters.

Top module: `fpulse_gen`

## Requirements
- R1: While `rst_n` is low the counter chain is at position 0. In the first cycle after reset, any output whose select is 1 or 2 drives its pulse high.
- R2: Select code 0 disables an output, and code 3 does the same. A disabled output drives its enable flag low and its pulse low. Codes 1 and 2 drive the enable flag high.
- R3: With select code 1, the pulse is high for the first half of each period and low for the second half.
- R4: With select code 2, the pulse is high from period position 0 up to, but not including, position W. W is the effective width.
- R5: The effective width is the width input clamped to the range 1 to period minus 1. A width of 0 gives 1, and a width of at least one period gives period minus 1.
- R6: The width input is captured only at position 0 of a period. A change made later in the period has no effect until the next period.
- R7: A multiframe period is exactly 4 frame periods long. Every multiframe period starts in the same cycle as a frame period, so every multiframe rising edge falls on a frame rising edge.
- R8: When `syncRestart` is high at a clock edge, the next cycle is position 0 of both the frame and the multiframe. Every enabled output is high in that cycle.
- R9: The counters keep running while an output is disabled. Re-enabling the output resumes it in phase with the unbroken timeline.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| syncRestart | input | 1 | Synchronous restart of the counter chain |
| frameSel | input | 2 | Frame output mode: 0 off, 1 square, 2 width, 3 off |
| frameWidth | input | 16 | Frame pulse width in reference cycles |
| superSel | input | 2 | Multiframe output mode, same encoding as frameSel |
| superWidth | input | 16 | Multiframe pulse width in reference cycles |
| framePulse | output | 1 | Frame pulse |
| frameOe | output | 1 | Frame output enable |
| superPulse | output | 1 | Multiframe pulse |
| superOe | output | 1 | Multiframe output enable |

## Verification
The bench runs square waves on both outputs across several multiframes. This separates a correct half-period threshold and a correct four-to-one period ratio from a divider that is off by one or slips its phase. Width patterns cover narrow, zero, oversized and mid-period-changed values, which separates clamping and start-of-period capture from a width that is used live. Disabling and later re-enabling an output, with both the off and the reserved code, checks that the phase comes back unbroken. A restart issued mid-frame checks that both outputs realign in the very next cycle.

// File: rtl/fpg_pkg.sv
`timescale 1ns/1ps
package fpg_pkg;
  typedef enum logic [1:0] {
    SEL_OFF    = 2'd0,
    SEL_SQUARE = 2'd1,
    SEL_WIDTH  = 2'd2,
    SEL_RSVD   = 2'd3
  } selMode_e;

  typedef struct packed {
    logic frameStart;
    logic superStart;
  } strobes_t;
endpackage

// File: rtl/fpg_ctrl.sv
`timescale 1ns/1ps
module fpg_ctrl
  import fpg_pkg::*;
#(
  parameter int FRAME_CYCLES     = 9720,
  parameter int FRAMES_PER_SUPER = 4,
  parameter int POS_W            = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             syncRestart,
  output strobes_t         strobes,
  output logic [POS_W-1:0] framePos,
  output logic [POS_W-1:0] superPos
);
  localparam int SUB_W = (FRAMES_PER_SUPER > 1) ? $clog2(FRAMES_PER_SUPER) : 1;
  localparam logic [POS_W-1:0] FRAME_LAST = POS_W'(FRAME_CYCLES - 1);
  localparam logic [SUB_W-1:0] SUB_LAST   = SUB_W'(FRAMES_PER_SUPER - 1);
  localparam logic [POS_W-1:0] FRAME_LEN  = POS_W'(FRAME_CYCLES);

  logic [POS_W-1:0] frameCnt;
  logic [SUB_W-1:0] subCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frameCnt <= '0;
      subCnt   <= '0;
    end else if (syncRestart) begin
      frameCnt <= '0;
      subCnt   <= '0;
    end else if (frameCnt == FRAME_LAST) begin
      frameCnt <= '0;
      subCnt   <= (subCnt == SUB_LAST) ? '0 : subCnt + 1'b1;
    end else begin
      frameCnt <= frameCnt + 1'b1;
    end
  end

  always_comb begin
    framePos           = frameCnt;
    superPos           = POS_W'(subCnt) * FRAME_LEN + frameCnt;
    strobes.frameStart = (frameCnt == '0);
    strobes.superStart = (frameCnt == '0) && (subCnt == '0);
  end
endmodule

// File: rtl/fpg_datapath.sv
`timescale 1ns/1ps
module fpg_datapath
  import fpg_pkg::*;
#(
  parameter int FRAME_CYCLES = 9720,
  parameter int SUPER_CYCLES = 38880,
  parameter int POS_W        = 16,
  parameter int WIDTH_W      = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  strobes_t           strobes,
  input  logic [POS_W-1:0]   framePos,
  input  logic [POS_W-1:0]   superPos,
  input  logic [1:0]         frameSel,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic [1:0]         superSel,
  input  logic [WIDTH_W-1:0] superWidth,
  output logic               framePulse,
  output logic               frameOe,
  output logic               superPulse,
  output logic               superOe
);
  localparam int NCH = 2;

  logic [POS_W-1:0]   posArr   [NCH];
  logic [1:0]         selArr   [NCH];
  logic [WIDTH_W-1:0] widthArr [NCH];
  logic               startArr [NCH];
  logic               pulseArr [NCH];
  logic               oeArr    [NCH];

  always_comb begin
    posArr[0]   = framePos;
    posArr[1]   = superPos;
    selArr[0]   = frameSel;
    selArr[1]   = superSel;
    widthArr[0] = frameWidth;
    widthArr[1] = superWidth;
    startArr[0] = strobes.frameStart;
    startArr[1] = strobes.superStart;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    localparam int PER = (g == 0) ? FRAME_CYCLES : SUPER_CYCLES;
    localparam logic [WIDTH_W-1:0] WMAX = WIDTH_W'(PER - 1);

    logic [WIDTH_W-1:0] widthHeld;
    logic [WIDTH_W-1:0] widthClamped;
    selMode_e           mode;

    always_comb begin
      if (widthArr[g] == '0)                 widthClamped = WIDTH_W'(1);
      else if (32'(widthArr[g]) >= 32'(PER)) widthClamped = WMAX;
      else                                   widthClamped = widthArr[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           widthHeld <= WIDTH_W'(1);
      else if (startArr[g]) widthHeld <= widthClamped;
    end

    always_comb begin
      mode = selMode_e'(selArr[g]);
      unique case (mode)
        SEL_SQUARE: begin
          oeArr[g]    = 1'b1;
          pulseArr[g] = 32'(posArr[g]) < 32'(PER / 2);
        end
        SEL_WIDTH: begin
          oeArr[g]    = 1'b1;
          pulseArr[g] = startArr[g] || (32'(posArr[g]) < 32'(widthHeld));
        end
        default: begin
          oeArr[g]    = 1'b0;
          pulseArr[g] = 1'b0;
        end
      endcase
    end
  end

  assign framePulse = pulseArr[0];
  assign frameOe    = oeArr[0];
  assign superPulse = pulseArr[1];
  assign superOe    = oeArr[1];
endmodule

// File: rtl/fpulse_gen.sv
`timescale 1ns/1ps
module fpulse_gen
  import fpg_pkg::*;
#(
  parameter int FRAME_CYCLES     = 9720,
  parameter int FRAMES_PER_SUPER = 4,
  parameter int WIDTH_W          = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               syncRestart,
  input  logic [1:0]         frameSel,
  input  logic [WIDTH_W-1:0] frameWidth,
  input  logic [1:0]         superSel,
  input  logic [WIDTH_W-1:0] superWidth,
  output logic               framePulse,
  output logic               frameOe,
  output logic               superPulse,
  output logic               superOe
);
  localparam int SUPER_CYCLES = FRAME_CYCLES * FRAMES_PER_SUPER;
  localparam int POS_W        = $clog2(SUPER_CYCLES);

  strobes_t         strobes;
  logic [POS_W-1:0] framePos;
  logic [POS_W-1:0] superPos;

  fpg_ctrl #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .FRAMES_PER_SUPER(FRAMES_PER_SUPER),
    .POS_W(POS_W)
  ) ctrl_i (
    .clk(clk),
    .rst_n(rst_n),
    .syncRestart(syncRestart),
    .strobes(strobes),
    .framePos(framePos),
    .superPos(superPos)
  );

  fpg_datapath #(
    .FRAME_CYCLES(FRAME_CYCLES),
    .SUPER_CYCLES(SUPER_CYCLES),
    .POS_W(POS_W),
    .WIDTH_W(WIDTH_W)
  ) dp_i (
    .clk(clk),
    .rst_n(rst_n),
    .strobes(strobes),
    .framePos(framePos),
    .superPos(superPos),
    .frameSel(frameSel),
    .frameWidth(frameWidth),
    .superSel(superSel),
    .superWidth(superWidth),
    .framePulse(framePulse),
    .frameOe(frameOe),
    .superPulse(superPulse),
    .superOe(superOe)
  );
endmodule

// File: rtl/fpulse_gen_chk.sv
`timescale 1ns/1ps
module fpulse_gen_chk #(
  parameter int FRAME_CYCLES = 9720,
  parameter int WIDTH_W      = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               syncRestart,
  input logic [1:0]         frameSel,
  input logic [WIDTH_W-1:0] frameWidth,
  input logic [1:0]         superSel,
  input logic [WIDTH_W-1:0] superWidth,
  input logic               framePulse,
  input logic               frameOe,
  input logic               superPulse,
  input logic               superOe
);
  logic [31:0] hiRun;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                         hiRun <= '0;
    else if (syncRestart || !(framePulse && frameSel == 2'd1)) hiRun <= '0;
    else                                                hiRun <= hiRun + 1'b1;
  end

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!frameOe |-> !framePulse) and (!superOe |-> !superPulse)); // R2

  AST_SQUARE_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (framePulse && frameSel == 2'd1) |-> (hiRun < 32'(FRAME_CYCLES / 2))); // R3

  AST_EDGE_COINCIDE: assert property (@(posedge clk) disable iff (!rst_n)
    (superOe && frameOe && $rose(superPulse) && $stable(superSel)) |-> framePulse); // R7

  AST_RESTART_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    syncRestart |=> ((!frameOe || framePulse) && (!superOe || superPulse))); // R8
endmodule

bind fpulse_gen fpulse_gen_chk #(
  .FRAME_CYCLES(FRAME_CYCLES),
  .WIDTH_W(WIDTH_W)
) chk_i (.*);

// File: tb/fpulse_gen_tb_top.sv
`timescale 1ns/1ps
module fpulse_gen_tb_top;
  localparam int F = 10;
  localparam int N = 4;
  localparam int S = F * N;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        syncRestart = 1'b0;
  logic [1:0]  frameSel = 2'd1;
  logic [15:0] frameWidth = 16'd3;
  logic [1:0]  superSel = 2'd1;
  logic [15:0] superWidth = 16'd5;
  logic        framePulse, frameOe, superPulse, superOe;

  int errors = 0;
  int checks = 0;

  // model timeline (from requirements)
  int spos = 0;
  int wl8 = 1;
  int wl2 = 1;

  always #5 clk = ~clk;

  fpulse_gen #(.FRAME_CYCLES(F), .FRAMES_PER_SUPER(N), .WIDTH_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .syncRestart(syncRestart),
    .frameSel(frameSel), .frameWidth(frameWidth),
    .superSel(superSel), .superWidth(superWidth),
    .framePulse(framePulse), .frameOe(frameOe),
    .superPulse(superPulse), .superOe(superOe)
  );

  function automatic int clampW(int w, int per);
    if (w == 0) return 1;
    if (w >= per) return per - 1;
    return w;
  endfunction

  function automatic logic expPulse(int pos, int per, logic [1:0] sel, int wl);
    case (sel)
      2'd1: return pos < per / 2;
      2'd2: return (pos == 0) || (pos < wl);
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      spos <= 0; wl8 <= 1; wl2 <= 1;
    end else begin
      if (spos % F == 0) wl8 <= clampW(int'(frameWidth), F);
      if (spos == 0)     wl2 <= clampW(int'(superWidth), S);
      spos <= syncRestart ? 0 : ((spos == S - 1) ? 0 : spos + 1);
    end
  end

  task automatic check1(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at spos=%0d", tag, act, exp, spos);
    end
  endtask

  task automatic runCheck(int n, string tag);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check1({tag, " frameOe"}, frameOe, (frameSel == 2'd1 || frameSel == 2'd2));
      check1({tag, " superOe"}, superOe, (superSel == 2'd1 || superSel == 2'd2));
      check1({tag, " framePulse"}, framePulse, expPulse(spos % F, F, frameSel, wl8));
      check1({tag, " superPulse"}, superPulse, expPulse(spos, S, superSel, wl2));
      if (spos == 0 && superOe && frameOe)
        check1({tag, " R7 coincident start"}, framePulse, 1'b1);
    end
  endtask

  task automatic waitPos(int p);
    while (spos != p) @(negedge clk);
  endtask

  task automatic tReset();
    frameSel = 2'd1; superSel = 2'd2; superWidth = 16'd7;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check1("R1 reset framePulse", framePulse, 1'b1);
    check1("R1 reset superPulse", superPulse, 1'b1);
    rst_n = 1'b1;
    runCheck(1, "R1");
  endtask

  task automatic tSquare();
    frameSel = 2'd1; superSel = 2'd1;
    runCheck(3 * S, "R3 R7 square");
  endtask

  task automatic tWidth();
    waitPos(S - 1);
    frameSel = 2'd2; frameWidth = 16'd3;
    superSel = 2'd2; superWidth = 16'd17;
    runCheck(2 * S, "R4 width");
  endtask

  task automatic tClamp();
    waitPos(S - 1);
    frameWidth = 16'd0; superWidth = 16'd40000;
    runCheck(S, "R5 clamp low/high");
    frameWidth = 16'd50; superWidth = 16'd0;
    runCheck(S, "R5 clamp high/low");
  endtask

  task automatic tMidChange();
    frameWidth = 16'd4; superWidth = 16'd6;
    waitPos(S + 0 - S + 5);
    frameWidth = 16'd8; superWidth = 16'd30;
    runCheck(S + 3, "R6 mid-period change");
  endtask

  task automatic tDisable();
    frameSel = 2'd0; superSel = 2'd3;
    runCheck(13, "R2 disabled");
    frameSel = 2'd3; superSel = 2'd0;
    runCheck(7, "R2 reserved");
    frameSel = 2'd1; superSel = 2'd1;
    runCheck(S, "R9 re-enable phase");
  endtask

  task automatic tRestart();
    waitPos(F + 6);
    syncRestart = 1'b1;
    @(negedge clk);
    syncRestart = 1'b0;
    check1("R8 restart framePulse", framePulse, 1'b1);
    check1("R8 restart superPulse", superPulse, 1'b1);
    runCheck(S, "R8 after restart");
    frameSel = 2'd2; superSel = 2'd2; frameWidth = 16'd2; superWidth = 16'd9;
    waitPos(27);
    syncRestart = 1'b1;
    runCheck(1, "R8 restart edge");
    syncRestart = 1'b0;
    runCheck(S, "R8 width after restart");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tReset();
    tSquare();
    tWidth();
    tClamp();
    tMidChange();
    tDisable();
    tRestart();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule